// File: doc/BRIEF.md
# Address-Polling Bus Arbiter

This block is a central arbiter that shares one bus among several masters without a grant wire for each of them. Each clock it puts a binary master address on a shared poll bus. While the bus is free, that address steps through every master in turn. Each master compares the poll bus with its own fixed address. A master that is requesting when its address appears claims the bus by raising its share of the shared busy line. Polling then freezes until that master lets go.

The per-master address comparators and ownership flags are built inside the block, one for each master. The block has no data stream, so every pin is a plain level signal. A master asks for the bus by holding its request bit high, and it gives the bus back by lowering that bit. The owner flags and the encoded owner index are brought out so that the arbitration result can be checked.

Top module: `poll_arbiter`

## Requirements
- R1: A synchronous active-high reset sets the poll address to 0, the busy line low and every owner flag low.
- R2: While busy is low and no master claims the bus, the poll address rises by one on each clock.
- R3: The poll address wraps from N-1 to 0, including when N is not a power of two.
- R4: If busy is low and the master whose index equals the poll address is requesting, busy is high from the next clock. That master's owner flag (bit index = master number) is set, owner_idx equals its number, and the poll address keeps its value.
- R5: A request from a master whose index differs from the poll address has no effect while busy is low. Busy stays low and polling keeps advancing.
- R6: While the owner keeps its request high, it stays owner, busy stays high and the poll address holds. Requests from other masters have no effect.
- R7: When the owner lowers its request, busy and its owner flag are low after the next clock. The poll address is then the owner's index plus one, modulo N.
- R8: At most one owner flag is ever set. While busy is high, owner_idx and poll_addr both equal the index of the set flag.
- R9: With no request pending, the poll address keeps cycling and busy stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_MASTERS | Request level, one bit per master |
| poll_addr | output | ADDR_W | Broadcast master address |
| busy | output | 1 | Shared busy line, the OR of all owner flags |
| owner_onehot | output | N_MASTERS | Owner flag per master |
| owner_idx | output | ADDR_W | Encoded owner number, 0 when busy is low |

## Verification
A poll counter that skips, repeats or wraps wrongly shows on poll_addr within one clock while the bus is idle. It also changes which master wins the next claim. A lost or stuck owner flag shows on the next clock as a busy level that disagrees with the request history, or as an owner_idx that differs from poll_addr. A wrong resume point after release appears on poll_addr on the very cycle busy falls. Random request traffic is compared cycle by cycle against a reference model built from the requirements. Directed sequences cover the claim, hold, release and wrap cases.

// File: rtl/poll_arb_pkg.sv
package poll_arb_pkg;
  // Next poll position, wrapping at the number of masters.
  function automatic int unsigned wrap_inc(int unsigned cur, int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/poll_sequencer.sv
module poll_sequencer #(
  parameter int N_MASTERS = 5,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              freeze,
  output logic [ADDR_W-1:0] poll_addr
);
  import poll_arb_pkg::*;

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(N_MASTERS - 1);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)
      addr_q <= '0;
    else if (!freeze)
      addr_q <= (addr_q == LAST) ? '0 : addr_q + ADDR_W'(1);
  end

  assign poll_addr = addr_q;
endmodule

// File: rtl/poll_master_port.sv
module poll_master_port #(
  parameter int ADDR_W = 3,
  parameter int ID     = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] poll_addr,
  input  logic              busy,
  output logic              own,
  output logic              own_next
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ID);

  logic addr_hit;

  assign addr_hit = (poll_addr == MY_ADDR);

  // Claim on an idle bus when addressed; keep ownership while requesting.
  always_comb begin
    if (own)
      own_next = req;
    else
      own_next = req && addr_hit && !busy;
  end

  always_ff @(posedge clk) begin
    if (rst) own <= 1'b0;
    else     own <= own_next;
  end
endmodule

// File: rtl/owner_encoder.sv
module owner_encoder #(
  parameter int N_MASTERS = 5,
  parameter int ADDR_W    = 3
) (
  input  logic [N_MASTERS-1:0] flags,
  output logic [ADDR_W-1:0]    idx
);
  always_comb begin
    idx = '0;
    for (int k = 0; k < N_MASTERS; k++)
      if (flags[k]) idx = idx | ADDR_W'(k);
  end
endmodule

// File: rtl/poll_arbiter.sv
module poll_arbiter #(
  parameter int N_MASTERS = 5,
  parameter int ADDR_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] req,
  output logic [ADDR_W-1:0]    poll_addr,
  output logic                 busy,
  output logic [N_MASTERS-1:0] owner_onehot,
  output logic [ADDR_W-1:0]    owner_idx
);
  logic [N_MASTERS-1:0] own_q;
  logic [N_MASTERS-1:0] own_d;
  logic                 hold_poll;

  assign busy      = |own_q;
  assign hold_poll = |own_d;

  poll_sequencer #(.N_MASTERS(N_MASTERS), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .freeze    (hold_poll),
    .poll_addr (poll_addr)
  );

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_port
    poll_master_port #(.ADDR_W(ADDR_W), .ID(g)) u_port (
      .clk       (clk),
      .rst       (rst),
      .req       (req[g]),
      .poll_addr (poll_addr),
      .busy      (busy),
      .own       (own_q[g]),
      .own_next  (own_d[g])
    );
  end

  owner_encoder #(.N_MASTERS(N_MASTERS), .ADDR_W(ADDR_W)) u_enc (
    .flags (own_q),
    .idx   (owner_idx)
  );

  assign owner_onehot = own_q;
endmodule

// File: rtl/poll_arbiter_chk.sv
module poll_arbiter_chk #(
  parameter int N_MASTERS = 5,
  parameter int ADDR_W    = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N_MASTERS-1:0] req,
  input logic [ADDR_W-1:0]    poll_addr,
  input logic                 busy,
  input logic [N_MASTERS-1:0] owner_onehot,
  input logic [ADDR_W-1:0]    owner_idx
);
  import poll_arb_pkg::*;

  // R8
  single_owner_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(owner_onehot));

  // R8
  idx_matches_poll_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (owner_idx == poll_addr && owner_onehot[owner_idx]));

  // R2
  idle_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !req[poll_addr]) |=>
      (!busy && poll_addr == ADDR_W'(wrap_inc(int'($past(poll_addr)), N_MASTERS))));

  // R4
  claim_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && req[poll_addr]) |=> (busy && owner_idx == $past(poll_addr)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && req[owner_idx]) |=> (busy && $stable(owner_idx) && $stable(poll_addr)));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !req[owner_idx]) |=>
      (!busy && poll_addr == ADDR_W'(wrap_inc(int'($past(owner_idx)), N_MASTERS))));
endmodule

bind poll_arbiter poll_arbiter_chk #(.N_MASTERS(N_MASTERS), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req          (req),
  .poll_addr    (poll_addr),
  .busy         (busy),
  .owner_onehot (owner_onehot),
  .owner_idx    (owner_idx)
);

// File: tb/test_poll_arbiter.sv
module test_poll_arbiter;
  localparam int N  = 5;
  localparam int AW = 3;
  localparam time CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0;
  logic [AW-1:0] poll_addr;
  logic          busy;
  logic [N-1:0]  owner_onehot;
  logic [AW-1:0] owner_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Reference state built from the requirements.
  int unsigned   m_poll  = 0;
  logic [N-1:0]  m_own   = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  poll_arbiter #(.N_MASTERS(N)) i_poll_arbiter (
    .clk(clk), .rst(rst), .req(req), .poll_addr(poll_addr), .busy(busy),
    .owner_onehot(owner_onehot), .owner_idx(owner_idx)
  );

  function automatic int unsigned inc_mod(int unsigned a);
    return (a + 1 >= N) ? 0 : a + 1;
  endfunction

  function automatic int unsigned owner_of(logic [N-1:0] f);
    int unsigned r = 0;
    for (int k = 0; k < N; k++) if (f[k]) r = k;
    return r;
  endfunction

  always @(posedge clk) begin
    logic [N-1:0] nxt;
    if (rst) begin
      m_poll <= 0;
      m_own  <= '0;
    end else begin
      if (|m_own) nxt = m_own & req;
      else begin
        nxt = '0;
        if (req[m_poll]) nxt[m_poll] = 1'b1;
      end
      m_own  <= nxt;
      if (!(|nxt)) m_poll <= inc_mod(m_poll);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string ptag;
    ptag = (|m_own) ? "R6" : ((m_poll == 0) ? "R3" : "R2");
    check(poll_addr == AW'(m_poll), ptag, poll_addr, m_poll);
    check(busy == (|m_own), "R4", busy, |m_own);
    check(owner_onehot == m_own, "R8", owner_onehot, m_own);
    if (|m_own) check(owner_idx == AW'(owner_of(m_own)), "R8", owner_idx, owner_of(m_own));
  endtask

  task automatic cycle(input logic [N-1:0] r);
    req = r;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] r;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(poll_addr == 0, "R1", poll_addr, 0);
    check(busy == 1'b0, "R1", busy, 0);
    check(owner_onehot == '0, "R1", owner_onehot, 0);
    rst = 1'b0;

    // R9 / R2 / R3: idle cycling with wrap
    for (int c = 0; c < 12; c++) begin
      cycle('0);
      check(poll_addr == AW'((c + 1) % N), "R9", poll_addr, (c + 1) % N);
      check(!busy, "R9", busy, 0);
    end

    // R5: master 3 requests while poll at 0; no effect until addressed
    while (poll_addr != 0) cycle('0);
    cycle(5'b01000);
    check(!busy && poll_addr == 1, "R5", poll_addr, 1);
    cycle(5'b01000);
    check(!busy && poll_addr == 2, "R5", poll_addr, 2);
    cycle(5'b01000);
    check(!busy && poll_addr == 3, "R5", busy, 0);
    // R4: claim
    cycle(5'b01000);
    check(busy && owner_idx == 3 && poll_addr == 3, "R4", owner_idx, 3);
    // R6: others cannot take it
    for (int c = 0; c < 4; c++) begin
      cycle(5'b11111);
      check(owner_onehot == 5'b01000 && poll_addr == 3, "R6", owner_onehot, 8);
    end
    // R7: release resumes after owner
    cycle(5'b10111);
    check(!busy && poll_addr == 4, "R7", poll_addr, 4);
    cycle(5'b10111);
    check(busy && owner_idx == 4, "R4", owner_idx, 4);
    // R7 + R3: release of last master wraps to 0
    cycle(5'b00111);
    check(!busy && poll_addr == 0, "R7", poll_addr, 0);

    // Random traffic with sticky requests
    for (int c = 0; c < 3000; c++) begin
      r = '0;
      for (int k = 0; k < N; k++) begin
        if (m_own[k]) r[k] = ($urandom % 8) != 0;
        else          r[k] = ($urandom % 4) == 0;
      end
      cycle(r);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule